// File: doc/BRIEF.md
# Chainable Up-Counting Timer with Synchronized Start

This block is a 16-bit up-counter with a programmable prescaler and an auto-reload limit. It also has a trigger input stage that can start the counter, and a trigger output that other instances can take as their start input. Two or more instances are chained by wiring one instance's trigger output to an internal trigger input of the next. A single rising edge on the first instance's external input then starts every counter on the same clock cycle.

The first instance (the leader) can delay its own count-enable path by exactly the number of cycles a follower needs to synchronize and detect the forwarded trigger. With this delay the leader and the followers step together. Without it, the leader runs ahead by that many cycles. Software sets the mode, the trigger source and the timing through a small write-only register port. It can reinitialize the counter, preload a counter value to get an offset between chained timers, and choose whether a debug halt freezes the count.

The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `casc_timer`

## Requirements
- R1: After reset, `cnt` is 0, `tif` is 0 and `trgo` is 0. The limit register resets to all ones and the prescaler value resets to 0.
- R2: Control register (address 0) bits [2:0] select what drives the trigger output. Code 001 drives `trgo` with the count-enable bit. Any other code holds `trgo` low.
- R3: Control bits [10:8] select the slave mode. With code 110, a rising edge on the selected trigger source sets the count-enable bit (control bit 13). The source goes through a 2-flop synchronizer and an edge detector, so enable rises on the third rising clock edge after the source changes.
- R4: A trigger edge never clears or reloads the counter. An edge that arrives while the counter is already enabled only sets `tif` again.
- R5: Control bits [6:4] choose the trigger source. Code 100 selects `ext_ti`. Codes 000 to 011 select `itrg[0]` to `itrg[3]`. Any other code selects a constant low.
- R6: `tif` is set on any detected trigger edge while the slave mode is not 000. It stays set until software writes 0 to bit 0 at address 4; a write of 1 there leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: With control bit 12 set, counting starts 3 cycles (synchronizer depth plus one) after count-enable rises. A follower started by this instance's `trgo` then shows the same `cnt` on every cycle. With bit 12 clear, the leader's count runs 3 cycles ahead of the follower.
- R8: Writing control bit 15 as 1 sets the counter and the prescaler phase to 0 and loads the prescaler value (address 2) into the active prescaler.
- R9: While enabled, `cnt` increments once every (prescaler+1) cycles. After it reaches the limit (address 3) it goes to 0. A write to address 1 loads `cnt`. While disabled, `cnt` holds.
- R10: While `dbg_halt` is high and control bit 14 is set, `cnt` holds. With bit 14 clear, `dbg_halt` has no effect.
- R11: With slave mode 000, trigger edges change neither the count-enable bit nor `tif`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0 control, 1 counter, 2 prescaler, 3 limit, 4 status |
| cfg_wdata | input | 16 | Register write data |
| ext_ti | input | 1 | External trigger pin |
| itrg | input | N_ITRG | Internal triggers from other instances |
| dbg_halt | input | 1 | Debug-halt indication |
| trgo | output | 1 | Trigger output toward other instances |
| tif | output | 1 | Sticky trigger flag |
| cnt | output | CNT_W | Current counter value |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, four internal triggers and a two-stage synchronizer. These defaults keep the start latency (3 cycles) and the follower lag (6 cycles) short enough to check cycle by cycle. Two instances are chained leader to follower, and the bench compares their counters on every cycle with the delay both enabled and disabled. A sweep over prescaler values 0 to 3 and limits 1 to 4 reaches every wrap and prescaler phase, with each expected count computed as (cycles/(psc+1)) mod (limit+1).

// File: rtl/casc_timer_pkg.sv
`timescale 1ns/1ps
package casc_timer_pkg;
  localparam int unsigned CFG_AW = 3;
  localparam int unsigned CFG_DW = 16;

  localparam logic [CFG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [CFG_AW-1:0] A_CNT  = 3'd1;
  localparam logic [CFG_AW-1:0] A_PSC  = 3'd2;
  localparam logic [CFG_AW-1:0] A_LIM  = 3'd3;
  localparam logic [CFG_AW-1:0] A_STAT = 3'd4;

  localparam int unsigned OUTSEL_LSB = 0;
  localparam int unsigned SRCSEL_LSB = 4;
  localparam int unsigned SLVMD_LSB  = 8;
  localparam int unsigned ALIGN_BIT  = 12;
  localparam int unsigned RUN_BIT    = 13;
  localparam int unsigned HALT_BIT   = 14;
  localparam int unsigned INIT_BIT   = 15;

  localparam logic [2:0] OUTSEL_RUN = 3'b001;
  localparam logic [2:0] SRC_EXT    = 3'b100;
  localparam logic [2:0] SLV_OFF    = 3'b000;
  localparam logic [2:0] SLV_START  = 3'b110;
endpackage

// File: rtl/ct_trig_sync.sv
`timescale 1ns/1ps
module ct_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic              prev_q;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign rise = sr_q[STAGES-1] & ~prev_q;

  // R3: a detected edge lasts a single cycle
  p_edge_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ct_time_base.sv
`timescale 1ns/1ps
module ct_time_base #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         init,
  input  logic         ld_we,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] psc_val,
  input  logic [W-1:0] lim_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] psc_act_q, psc_act_d;
  logic [W-1:0] phase_q, phase_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    psc_act_d = psc_act_q;
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    if (init) begin
      psc_act_d = psc_val;
      phase_d   = '0;
      cnt_d     = '0;
    end else begin
      if (run) begin
        if (phase_q == psc_act_q) begin
          phase_d   = '0;
          psc_act_d = psc_val;
          cnt_d     = (cnt_q == lim_val) ? '0 : cnt_q + 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      if (ld_we) begin
        cnt_d = ld_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act_q <= '0;
      phase_q   <= '0;
      cnt_q     <= '0;
    end else begin
      psc_act_q <= psc_act_d;
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R8: reinit clears count and prescaler phase
  p_reinit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (cnt_q == '0 && phase_q == '0));
  // R9: wrap to zero after the limit
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !init && !ld_we && phase_q == psc_act_q && cnt_q == lim_val) |=> cnt_q == '0);
  // R9: hold while disabled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !init && !ld_we) |=> $stable(cnt_q));
endmodule

// File: rtl/casc_timer.sv
`timescale 1ns/1ps
module casc_timer
  import casc_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned N_ITRG      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              ext_ti,
  input  logic [N_ITRG-1:0] itrg,
  input  logic              dbg_halt,
  output logic              trgo,
  output logic              tif,
  output logic [CNT_W-1:0]  cnt
);
  localparam int unsigned DLY = SYNC_STAGES + 1;

  // reset released synchronously
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [2:0] outsel_q, outsel_d, srcsel_q, srcsel_d, slvmd_q, slvmd_d;
  logic       align_q, align_d, run_q, run_d, hfrz_q, hfrz_d, tif_q, tif_d;
  logic [CNT_W-1:0] psc_q, psc_d, lim_q, lim_d;
  logic [DLY-1:0]   dly_q, dly_d;
  logic we_ctrl, we_cnt, we_psc, we_lim, we_stat, init;
  logic trg_src, trg_edge, cnt_run;

  assign we_ctrl = cfg_we && cfg_addr == A_CTRL;
  assign we_cnt  = cfg_we && cfg_addr == A_CNT;
  assign we_psc  = cfg_we && cfg_addr == A_PSC;
  assign we_lim  = cfg_we && cfg_addr == A_LIM;
  assign we_stat = cfg_we && cfg_addr == A_STAT;
  assign init    = we_ctrl && cfg_wdata[INIT_BIT];

  always_comb begin
    trg_src = 1'b0;
    if (srcsel_q == SRC_EXT) trg_src = ext_ti;
    for (int i = 0; i < int'(N_ITRG); i++) begin
      if (srcsel_q == 3'(i)) trg_src = itrg[i];
    end
  end

  ct_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .din(trg_src), .rise(trg_edge)
  );

  always_comb begin
    outsel_d = outsel_q;
    srcsel_d = srcsel_q;
    slvmd_d  = slvmd_q;
    align_d  = align_q;
    run_d    = run_q;
    hfrz_d   = hfrz_q;
    psc_d    = psc_q;
    lim_d    = lim_q;
    tif_d    = tif_q;
    if (we_ctrl) begin
      outsel_d = cfg_wdata[OUTSEL_LSB +: 3];
      srcsel_d = cfg_wdata[SRCSEL_LSB +: 3];
      slvmd_d  = cfg_wdata[SLVMD_LSB +: 3];
      align_d  = cfg_wdata[ALIGN_BIT];
      run_d    = cfg_wdata[RUN_BIT];
      hfrz_d   = cfg_wdata[HALT_BIT];
    end
    if (we_psc) psc_d = cfg_wdata[CNT_W-1:0];
    if (we_lim) lim_d = cfg_wdata[CNT_W-1:0];
    if (we_stat && !cfg_wdata[0]) tif_d = 1'b0;
    if (trg_edge && slvmd_q != SLV_OFF) tif_d = 1'b1;
    if (trg_edge && slvmd_q == SLV_START) run_d = 1'b1;
  end

  // count-enable delay line for aligned start
  assign dly_d = {dly_q[DLY-2:0], run_q};

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      outsel_q <= 3'b000;
      srcsel_q <= 3'b000;
      slvmd_q  <= SLV_OFF;
      align_q  <= 1'b0;
      run_q    <= 1'b0;
      hfrz_q   <= 1'b0;
      psc_q    <= '0;
      lim_q    <= '1;
      tif_q    <= 1'b0;
      dly_q    <= '0;
    end else begin
      outsel_q <= outsel_d;
      srcsel_q <= srcsel_d;
      slvmd_q  <= slvmd_d;
      align_q  <= align_d;
      run_q    <= run_d;
      hfrz_q   <= hfrz_d;
      psc_q    <= psc_d;
      lim_q    <= lim_d;
      tif_q    <= tif_d;
      dly_q    <= dly_d;
    end
  end

  assign cnt_run = (align_q ? dly_q[DLY-1] : run_q) & ~(dbg_halt & hfrz_q);

  ct_time_base #(.W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_i), .run(cnt_run), .init(init),
    .ld_we(we_cnt), .ld_val(cfg_wdata[CNT_W-1:0]),
    .psc_val(psc_q), .lim_val(lim_q), .cnt(cnt)
  );

  assign trgo = (outsel_q == OUTSEL_RUN) ? run_q : 1'b0;
  assign tif  = tif_q;

  // R3: start-mode edge sets the enable
  p_trig_start_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (trg_edge && slvmd_q == SLV_START) |=> run_q);
  // R6: flag stays until cleared
  p_tif_sticky_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (tif_q && !(we_stat && !cfg_wdata[0])) |=> tif_q);
  // R10: frozen count holds
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (dbg_halt && hfrz_q && !cfg_we) |=> $stable(cnt));
  // R11: slave mode off ignores edges
  p_slave_off_r11: assert property (@(posedge clk) disable iff (!rst_i)
    (slvmd_q == SLV_OFF && !we_ctrl) |=> $stable(run_q));
endmodule

// File: tb/test_casc_timer.sv
`timescale 1ns/1ps
module test_casc_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_m = 1'b0, we_s = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic ti1 = 1'b0;
  logic dbg_halt = 1'b0;
  logic trgo_m, trgo_s, tif_m, tif_s;
  logic [15:0] cnt_m, cnt_s;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  casc_timer i_casc_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_m), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ext_ti(ti1), .itrg(4'b0000), .dbg_halt(dbg_halt),
    .trgo(trgo_m), .tif(tif_m), .cnt(cnt_m)
  );

  casc_timer i_casc_timer_slv (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_s), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ext_ti(1'b0), .itrg({3'b000, trgo_m}), .dbg_halt(dbg_halt),
    .trgo(trgo_s), .tif(tif_s), .cnt(cnt_s)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic [2:0] mms, input logic [2:0] ts,
                                     input logic [2:0] sms, input logic msm,
                                     input logic cen, input logic frz, input logic ug);
    logic [15:0] v;
    v = '0;
    v[2:0] = mms; v[6:4] = ts; v[10:8] = sms;
    v[12] = msm; v[13] = cen; v[14] = frz; v[15] = ug;
    return v;
  endfunction

  task automatic wr(input bit slv, input logic [2:0] a, input logic [15:0] d);
    cfg_addr = a; cfg_wdata = d;
    if (slv) we_s = 1'b1; else we_m = 1'b1;
    @(negedge clk);
    we_m = 1'b0; we_s = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ti1 = 1'b0; dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chain_start(input logic msm);
    wr(0, 3'd2, 16'd0);
    wr(1, 3'd2, 16'd0);
    wr(0, 3'd0, cw(3'b001, 3'b100, 3'b110, msm, 1'b0, 1'b0, 1'b1));
    wr(1, 3'd0, cw(3'b000, 3'b000, 3'b110, 1'b0, 1'b0, 1'b0, 1'b1));
  endtask

  initial begin
    int v;
    int last;
    do_reset();
    // R1
    chk("R1 cnt", cnt_m, 0); chk("R1 tif", tif_m, 0); chk("R1 trgo", trgo_m, 0);
    chk("R1 cnt slave", cnt_s, 0);

    // aligned chain: R7, R3, R2, R6
    chain_start(1'b1);
    chk("R2 trgo before start", trgo_m, 0);
    ti1 = 1'b1;
    for (int c = 1; c <= 50; c++) begin
      @(negedge clk);
      if (c == 2) chk("R3 trgo not yet", trgo_m, 0);
      if (c == 3) begin chk("R3 R2 trgo up", trgo_m, 1); chk("R6 tif leader", tif_m, 1); end
      if (c == 5) chk("R6 tif follower early", tif_s, 0);
      if (c == 6) chk("R6 tif follower", tif_s, 1);
      chk("R7 leader cnt", cnt_m, (c > 6) ? c - 6 : 0);
      chk("R7 lockstep", cnt_s, cnt_m);
    end

    // R6 clear; R4 re-trigger only sets flag
    wr(0, 3'd4, 16'd0);
    chk("R6 cleared", tif_m, 0);
    last = cnt_m;
    ti1 = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R4 keeps counting", cnt_m, last + 1); last = cnt_m;
    end
    ti1 = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R4 no reset", cnt_m, last + 1); last = cnt_m;
      chk("R7 lockstep retrig", cnt_s, cnt_m);
    end
    chk("R4 flag again", tif_m, 1);
    wr(0, 3'd4, 16'd1);
    chk("R6 write one keeps", tif_m, 1);
    wr(0, 3'd4, 16'd0);
    chk("R6 write zero clears", tif_m, 0);

    // unaligned chain: leader 3 ahead
    do_reset();
    chain_start(1'b0);
    ti1 = 1'b1;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      chk("R7 lead cnt", cnt_m, (c > 3) ? c - 3 : 0);
      chk("R7 follower cnt", cnt_s, (c > 6) ? c - 6 : 0);
    end

    // prescaler / limit sweep: R8 R9
    do_reset();
    for (int p = 0; p < 4; p++) begin
      for (int a = 1; a <= 4; a++) begin
        wr(0, 3'd2, 16'(p));
        wr(0, 3'd3, 16'(a));
        wr(0, 3'd0, cw(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1));
        chk("R8 init zero", cnt_m, 0);
        for (int m = 1; m <= 24; m++) begin
          @(negedge clk);
          chk("R9 sweep", cnt_m, (m / (p + 1)) % (a + 1));
        end
      end
    end

    // R9 counter load and hold
    wr(0, 3'd2, 16'd0);
    wr(0, 3'd3, 16'd9);
    wr(0, 3'd0, cw(3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1));
    wr(0, 3'd1, 16'd7);
    chk("R9 load", cnt_m, 7);
    repeat (3) @(negedge clk);
    chk("R9 stopped hold", cnt_m, 7);
    wr(0, 3'd0, cw(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R9 from offset", cnt_m, 7);
    for (int m = 1; m <= 3; m++) begin
      @(negedge clk);
      chk("R9 offset count wrap", cnt_m, (7 + m) % 10);
    end

    // R10 freeze
    wr(0, 3'd0, cw(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0));
    dbg_halt = 1'b1;
    v = cnt_m;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 frozen", cnt_m, v);
    end
    wr(0, 3'd0, cw(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R10 last frozen", cnt_m, v);
    @(negedge clk);
    chk("R10 runs in halt when not frozen", cnt_m, (v + 1) % 10);
    dbg_halt = 1'b0;

    // R11 slave mode off, R5 source select
    do_reset();
    wr(0, 3'd0, cw(3'b001, 3'b100, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1));
    ti1 = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 no start", trgo_m, 0); chk("R11 no flag", tif_m, 0); chk("R11 cnt", cnt_m, 0);
    ti1 = 1'b0;
    repeat (4) @(negedge clk);
    wr(0, 3'd0, cw(3'b001, 3'b000, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0));
    ti1 = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 itrg0 ignores ext", trgo_m, 0); chk("R5 itrg0 no flag", tif_m, 0);
    ti1 = 1'b0;
    repeat (4) @(negedge clk);
    wr(0, 3'd0, cw(3'b001, 3'b101, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0));
    ti1 = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 code 101 none", trgo_m, 0); chk("R5 code 101 no flag", tif_m, 0);
    ti1 = 1'b0;
    repeat (4) @(negedge clk);
    wr(0, 3'd0, cw(3'b001, 3'b100, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0));
    ti1 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 ext start", trgo_m, 1);
    chk("R2 other code low", trgo_s, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule